// File: doc/BRIEF.md
# Processor break entry controller

This block is the break-handling control slice of a pipelined 32-bit processor. It accepts two external break sources: a maskable break that arrives as a held level, and a non-maskable break that arrives as a single-cycle pulse. When a break is taken, the instruction already in execute finishes normally. The instruction in decode is discarded, and the front end is redirected to a fixed break vector. The discarded instruction's PC goes to general register 16 as the return address.

On entry the block sets its break-active flag. It copies the live user-mode and virtual-mode bits into their shadow copies and then clears the live bits. While the break-active flag is set, later maskable breaks and the maskable interrupt are held off. A dedicated return instruction clears the flag, restores both mode bits from their shadows and redirects fetch to the address read from register 16. The surrounding pipeline can also load the mode bits directly, which models its move-to-status path.

All outputs are registered. A decision made on the inputs of cycle N appears on the outputs in cycle N+1.

Top module: `brk_entry_ctrl`

## Requirements
- R1: After reset the five status bits (break-active, user, virtual, user shadow, virtual shadow) are 0, and redirect, register write and interrupt-take are all low.
- R2: A maskable break seen while break-active is 0 and exception-busy is 0 raises `redir_o` in the next cycle, with `redir_pc_o` equal to BASE_VEC + 0x18. Holding the level afterwards causes no second entry.
- R3: In the same cycle as a break redirect, `rf_we_o` is 1, `rf_waddr_o` is 16 and `rf_wdata_o` equals the `dec_pc_i` value of the accepting cycle.
- R4: Break entry gives break-active = 1, user shadow = old user bit, virtual shadow = old virtual bit, and user = virtual = 0 in the next cycle.
- R5: A maskable break that arrives while break-active is 1 or exception-busy is 1 is ignored: no redirect, no write, status unchanged.
- R6: A non-maskable pulse is always accepted, even while break-active or exception-busy is 1. A re-entry saves the current (cleared) mode bits into the shadows.
- R7: When a break is accepted in a cycle, an interrupt request in that same cycle is not taken. When both break kinds arrive together, exactly one entry happens at the shared vector.
- R8: `irq_take_o` pulses one cycle after a request only when interrupt-enable is 1 and break-active is 0. Otherwise the request is ignored.
- R9: A return strobe clears break-active and restores user and virtual from their shadows. It also redirects to the `r16_val_i` value of that cycle, with no register write.
- R10: A return strobe that coincides with an accepted break is dropped. The break entry happens and break-active stays 1.
- R11: A mode write loads user and virtual from `mode_um_i` and `mode_vm_i`. It is ignored in any cycle that has a break entry or a return.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mbrk_req_i | input | 1 | Maskable break request, held level |
| nmbrk_pulse_i | input | 1 | Non-maskable break request, one-cycle pulse |
| irq_req_i | input | 1 | Maskable interrupt request |
| irq_en_i | input | 1 | Interrupt-enable status bit |
| exc_busy_i | input | 1 | Exception-in-progress status bit |
| rtb_i | input | 1 | Return-from-break instruction executes |
| mode_wr_i | input | 1 | Load the mode bits |
| mode_um_i | input | 1 | New user-mode value |
| mode_vm_i | input | 1 | New virtual-mode value |
| dec_pc_i | input | XLEN | PC of the instruction in decode |
| r16_val_i | input | XLEN | Current contents of register 16 |
| redir_o | output | 1 | Redirect fetch |
| redir_pc_o | output | XLEN | Redirect target |
| rf_we_o | output | 1 | Register-file write strobe |
| rf_waddr_o | output | RAW | Register-file write index (16) |
| rf_wdata_o | output | XLEN | Return address written |
| irq_take_o | output | 1 | Interrupt accepted |
| bip_o | output | 1 | Break-active flag |
| um_o | output | 1 | Live user-mode bit |
| vm_o | output | 1 | Live virtual-mode bit |
| ums_o | output | 1 | Saved user-mode bit |
| vms_o | output | 1 | Saved virtual-mode bit |

## Verification
The bench holds the maskable level for several cycles after entry. A design that does not gate on the break-active flag would redirect again and overwrite register 16 with a wrong PC. It fires a non-maskable pulse while busy and checks that a re-entry saves the already-cleared mode bits, which catches a design that saves stale or reset values. It also lines up a return with a non-maskable pulse, and a break with an interrupt or a mode write. A design with the wrong priority order would drop the entry, clear the flag while a handler runs, or take an interrupt in the middle of a break.

// File: rtl/brk_pkg.sv
package brk_pkg;

    // One winning event per cycle, in priority order of the arbiter.
    typedef enum logic [2:0] {
        EV_IDLE,
        EV_NMBRK,
        EV_MBRK,
        EV_RETURN,
        EV_MODEWR
    } ev_e;

    typedef struct packed {
        logic bip;
        logic um;
        logic vm;
        logic ums;
        logic vms;
    } stat_t;

    function automatic logic is_entry(ev_e ev);
        return (ev == EV_NMBRK) || (ev == EV_MBRK);
    endfunction

endpackage

// File: rtl/brk_arbiter.sv
module brk_arbiter
    import brk_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic mbrk_i,
    input  logic nmbrk_i,
    input  logic irq_i,
    input  logic ie_i,
    input  logic eip_i,
    input  logic rtb_i,
    input  logic mode_wr_i,
    input  logic bip_i,
    output ev_e  ev_o,
    output logic irq_take_o
);

    logic mbrk_ok;

    always_comb begin
        mbrk_ok = mbrk_i && !bip_i && !eip_i;
        ev_o    = EV_IDLE;
        if (nmbrk_i) begin
            ev_o = EV_NMBRK;
        end else if (mbrk_ok) begin
            ev_o = EV_MBRK;
        end else if (rtb_i) begin
            ev_o = EV_RETURN;
        end else if (mode_wr_i) begin
            ev_o = EV_MODEWR;
        end
        irq_take_o = irq_i && ie_i && !bip_i && !is_entry(ev_o);
    end

    // R5: a maskable entry is only chosen while nothing is in progress
    p_mbrk_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_o == EV_MBRK) |-> (!bip_i && !eip_i));

    // R8: interrupt acceptance respects enable and the break-active flag
    p_irq_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_take_o |-> (ie_i && !bip_i));

    // R10: a return never wins over a non-maskable pulse
    p_nm_over_ret_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (nmbrk_i && rtb_i) |-> (ev_o != EV_RETURN));

endmodule

// File: rtl/brk_status.sv
module brk_status
    import brk_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  ev_e   ev_i,
    input  logic  mode_um_i,
    input  logic  mode_vm_i,
    output stat_t stat_o
);

    stat_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        case (ev_i)
            EV_NMBRK, EV_MBRK: begin
                s_d.ums = s_q.um;
                s_d.vms = s_q.vm;
                s_d.um  = 1'b0;
                s_d.vm  = 1'b0;
                s_d.bip = 1'b1;
            end
            EV_RETURN: begin
                s_d.bip = 1'b0;
                s_d.um  = s_q.ums;
                s_d.vm  = s_q.vms;
            end
            EV_MODEWR: begin
                s_d.um = mode_um_i;
                s_d.vm = mode_vm_i;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign stat_o = s_q;

    // R4: entry sets the flag and moves the mode bits to the shadows
    p_entry_save_r4: assert property (@(posedge clk) disable iff (!rst_n)
        is_entry(ev_i) |=> (s_q.bip && !s_q.um && !s_q.vm
                            && s_q.ums == $past(s_q.um)
                            && s_q.vms == $past(s_q.vm)));

    // R9: return clears the flag and restores the mode bits
    p_ret_restore_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_i == EV_RETURN) |=> (!s_q.bip && s_q.um == $past(s_q.ums)
                                 && s_q.vm == $past(s_q.vms)));

    // R11: shadows move only on entry
    p_shadow_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !is_entry(ev_i) |=> ($stable(s_q.ums) && $stable(s_q.vms)));

endmodule

// File: rtl/brk_redirect.sv
module brk_redirect
    import brk_pkg::*;
#(
    parameter int          XLEN    = 32,
    parameter int          RAW     = 5,
    parameter logic [XLEN-1:0] VEC = '0,
    parameter int          RET_REG = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  ev_e             ev_i,
    input  logic            irq_take_i,
    input  logic [XLEN-1:0] dec_pc_i,
    input  logic [XLEN-1:0] r16_i,
    output logic            redir_o,
    output logic [XLEN-1:0] redir_pc_o,
    output logic            rf_we_o,
    output logic [RAW-1:0]  rf_waddr_o,
    output logic [XLEN-1:0] rf_wdata_o,
    output logic            irq_o
);

    localparam logic [RAW-1:0] RET_IDX = RET_REG[RAW-1:0];

    typedef struct packed {
        logic            redir;
        logic [XLEN-1:0] pc;
        logic            we;
        logic [XLEN-1:0] wdata;
        logic            irq;
    } out_t;

    out_t o_d, o_q;

    always_comb begin
        o_d       = '0;
        o_d.irq   = irq_take_i;
        if (is_entry(ev_i)) begin
            o_d.redir = 1'b1;
            o_d.pc    = VEC;
            o_d.we    = 1'b1;
            o_d.wdata = dec_pc_i;
        end else if (ev_i == EV_RETURN) begin
            o_d.redir = 1'b1;
            o_d.pc    = r16_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            o_q <= '0;
        end else begin
            o_q <= o_d;
        end
    end

    assign redir_o    = o_q.redir;
    assign redir_pc_o = o_q.pc;
    assign rf_we_o    = o_q.we;
    assign rf_waddr_o = RET_IDX;
    assign rf_wdata_o = o_q.wdata;
    assign irq_o      = o_q.irq;

    // R2 / R3: entry redirects to the vector and writes the decode PC
    p_entry_vec_r3: assert property (@(posedge clk) disable iff (!rst_n)
        is_entry(ev_i) |=> (redir_o && redir_pc_o == VEC && rf_we_o
                            && rf_wdata_o == $past(dec_pc_i)));

    // R9: return redirects to the register 16 value without a write
    p_ret_target_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_i == EV_RETURN) |=> (redir_o && !rf_we_o
                                 && redir_pc_o == $past(r16_i)));

    // R7: an interrupt is never accepted together with a break entry
    p_irq_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(irq_o && rf_we_o));

endmodule

// File: rtl/brk_entry_ctrl.sv
module brk_entry_ctrl
    import brk_pkg::*;
#(
    parameter int              XLEN     = 32,
    parameter int              RAW      = 5,
    parameter logic [XLEN-1:0] BASE_VEC = '0,
    parameter logic [XLEN-1:0] VEC_OFS  = 'h18,
    parameter int              RET_REG  = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            mbrk_req_i,
    input  logic            nmbrk_pulse_i,
    input  logic            irq_req_i,
    input  logic            irq_en_i,
    input  logic            exc_busy_i,
    input  logic            rtb_i,
    input  logic            mode_wr_i,
    input  logic            mode_um_i,
    input  logic            mode_vm_i,
    input  logic [XLEN-1:0] dec_pc_i,
    input  logic [XLEN-1:0] r16_val_i,
    output logic            redir_o,
    output logic [XLEN-1:0] redir_pc_o,
    output logic            rf_we_o,
    output logic [RAW-1:0]  rf_waddr_o,
    output logic [XLEN-1:0] rf_wdata_o,
    output logic            irq_take_o,
    output logic            bip_o,
    output logic            um_o,
    output logic            vm_o,
    output logic            ums_o,
    output logic            vms_o
);

    localparam logic [XLEN-1:0] BRK_VEC = BASE_VEC + VEC_OFS;

    ev_e   ev;
    logic  irq_take;
    stat_t stat;

    brk_arbiter u_arb (
        .clk        (clk),
        .rst_n      (rst_n),
        .mbrk_i     (mbrk_req_i),
        .nmbrk_i    (nmbrk_pulse_i),
        .irq_i      (irq_req_i),
        .ie_i       (irq_en_i),
        .eip_i      (exc_busy_i),
        .rtb_i      (rtb_i),
        .mode_wr_i  (mode_wr_i),
        .bip_i      (stat.bip),
        .ev_o       (ev),
        .irq_take_o (irq_take)
    );

    brk_status u_stat (
        .clk       (clk),
        .rst_n     (rst_n),
        .ev_i      (ev),
        .mode_um_i (mode_um_i),
        .mode_vm_i (mode_vm_i),
        .stat_o    (stat)
    );

    brk_redirect #(
        .XLEN    (XLEN),
        .RAW     (RAW),
        .VEC     (BRK_VEC),
        .RET_REG (RET_REG)
    ) u_redir (
        .clk        (clk),
        .rst_n      (rst_n),
        .ev_i       (ev),
        .irq_take_i (irq_take),
        .dec_pc_i   (dec_pc_i),
        .r16_i      (r16_val_i),
        .redir_o    (redir_o),
        .redir_pc_o (redir_pc_o),
        .rf_we_o    (rf_we_o),
        .rf_waddr_o (rf_waddr_o),
        .rf_wdata_o (rf_wdata_o),
        .irq_o      (irq_take_o)
    );

    assign bip_o = stat.bip;
    assign um_o  = stat.um;
    assign vm_o  = stat.vm;
    assign ums_o = stat.ums;
    assign vms_o = stat.vms;

    // R6: a non-maskable pulse always leaves the flag set
    p_nm_always_r6: assert property (@(posedge clk) disable iff (!rst_n)
        nmbrk_pulse_i |=> (bip_o && redir_o && rf_we_o));

    // R5: a blocked maskable request with nothing else pending changes nothing
    p_mbrk_blocked_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mbrk_req_i && (bip_o || exc_busy_i) && !nmbrk_pulse_i && !rtb_i)
        |=> !rf_we_o);

endmodule

// File: tb/sim_brk_entry_ctrl.sv
module sim_brk_entry_ctrl;

    localparam logic [31:0] BASE = 32'h0000_0200;
    localparam logic [31:0] VEC  = BASE + 32'h18;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mb = 0, nm = 0, irq = 0, ie = 0, eip = 0, rtb = 0;
    logic        mwr = 0, mum = 0, mvm = 0;
    logic [31:0] pc = '0, r16 = '0;
    logic        redir, we, irqt, bip, um, vm, ums, vms;
    logic [31:0] rpc, wdata;
    logic [4:0]  waddr;

    always #2 clk = ~clk;

    brk_entry_ctrl #(.BASE_VEC(BASE)) u0 (
        .clk(clk), .rst_n(rst_n), .mbrk_req_i(mb), .nmbrk_pulse_i(nm),
        .irq_req_i(irq), .irq_en_i(ie), .exc_busy_i(eip), .rtb_i(rtb),
        .mode_wr_i(mwr), .mode_um_i(mum), .mode_vm_i(mvm),
        .dec_pc_i(pc), .r16_val_i(r16),
        .redir_o(redir), .redir_pc_o(rpc), .rf_we_o(we), .rf_waddr_o(waddr),
        .rf_wdata_o(wdata), .irq_take_o(irqt), .bip_o(bip), .um_o(um),
        .vm_o(vm), .ums_o(ums), .vms_o(vms)
    );

    typedef struct {
        int          due;
        logic        redir;
        logic [31:0] pc;
        logic        we;
        logic [31:0] wd;
        logic        irq;
        logic [4:0]  st;
        string       tag;
    } exp_t;

    exp_t q[$];
    exp_t e;
    int   cyc = 0;
    int   n_chk = 0;
    int   n_fail = 0;
    logic m_bip = 0, m_um = 0, m_vm = 0, m_ums = 0, m_vms = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(bit ok, string tag, string what, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // monitor: compare the item due in this cycle
    always @(negedge clk) begin
        if (rst_n && q.size() > 0 && q[0].due == cyc) begin
            e = q.pop_front();
            chk(redir == e.redir && (!e.redir || rpc == e.pc), e.tag, "redirect",
                {31'd0, redir, rpc}, {31'd0, e.redir, e.pc});
            chk(we == e.we && (!e.we || (wdata == e.wd && waddr == 5'd16)), e.tag,
                "rf write", {26'd0, we, waddr, wdata}, {26'd0, e.we, 5'd16, e.wd});
            chk(irqt == e.irq, e.tag, "irq take", {63'd0, irqt}, {63'd0, e.irq});
            chk({bip, um, vm, ums, vms} == e.st, e.tag, "status",
                {59'd0, bip, um, vm, ums, vms}, {59'd0, e.st});
        end
    end

    // driver: apply one cycle of inputs and push the expected outcome
    task automatic step(logic i_mb, logic i_nm, logic i_irq, logic i_ie, logic i_eip,
                        logic i_rtb, logic i_mwr, logic i_mum, logic i_mvm,
                        logic [31:0] i_pc, logic [31:0] i_r16, string tag);
        exp_t x;
        logic entry, ret;
        @(posedge clk);
        #1;
        mb = i_mb; nm = i_nm; irq = i_irq; ie = i_ie; eip = i_eip; rtb = i_rtb;
        mwr = i_mwr; mum = i_mum; mvm = i_mvm; pc = i_pc; r16 = i_r16;
        entry = i_nm || (i_mb && !m_bip && !i_eip);
        ret   = !entry && i_rtb;
        x.due   = cyc + 1;
        x.tag   = tag;
        x.redir = entry || ret;
        x.pc    = entry ? VEC : i_r16;
        x.we    = entry;
        x.wd    = i_pc;
        x.irq   = !entry && i_irq && i_ie && !m_bip;
        if (entry) begin
            m_ums = m_um; m_vms = m_vm; m_um = 0; m_vm = 0; m_bip = 1;
        end else if (ret) begin
            m_bip = 0; m_um = m_ums; m_vm = m_vms;
        end else if (i_mwr) begin
            m_um = i_mum; m_vm = i_mvm;
        end
        x.st = {m_bip, m_um, m_vm, m_ums, m_vms};
        q.push_back(x);
    endtask

    task automatic idle(string tag);
        step(0,0,0,0,0,0,0,0,0, 32'h0, 32'h0, tag);
    endtask

    task automatic finish_run();
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk({bip, um, vm, ums, vms, redir, we, irqt} == 8'd0, "R1", "reset state",
            {56'd0, bip, um, vm, ums, vms, redir, we, irqt}, 64'd0);
        rst_n = 1'b1;
        idle("R1");
        idle("R1");
        // R11: load both mode bits
        step(0,0,0,0,0,0,1,1,1, 32'h0, 32'h0, "R11");
        // R2 R3 R4: maskable entry, then held level (no re-entry)
        step(1,0,0,0,0,0,0,0,0, 32'h0000_1000, 32'h0, "R2");
        step(1,0,0,0,0,0,0,0,0, 32'h0000_1004, 32'h0, "R2");
        step(1,0,0,0,0,0,0,0,0, 32'h0000_1008, 32'h0, "R5");
        // R8: interrupt ignored while break-active
        step(0,0,1,1,0,0,0,0,0, 32'h0, 32'h0, "R8");
        // R9: return restores mode bits and redirects to r16
        step(0,0,0,0,0,1,0,0,0, 32'h0, 32'h0000_1000, "R9");
        idle("R9");
        // R8: interrupt with enable low, then high
        step(0,0,1,0,0,0,0,0,0, 32'h0, 32'h0, "R8");
        step(0,0,1,1,0,0,0,0,0, 32'h0, 32'h0, "R8");
        // R5: exception busy blocks maskable
        step(1,0,0,0,1,0,0,0,0, 32'h0000_2000, 32'h0, "R5");
        // R6: non-maskable while exception busy, then again while break-active
        step(0,1,0,0,1,0,0,0,0, 32'h0000_2004, 32'h0, "R6");
        step(0,1,0,0,0,0,0,0,0, 32'h0000_3000, 32'h0, "R6");
        // R10: return together with a non-maskable pulse
        step(0,1,0,0,0,1,0,0,0, 32'h0000_3100, 32'h0000_5555, "R10");
        step(0,0,0,0,0,1,0,0,0, 32'h0, 32'h0000_3000, "R9");
        step(0,0,0,0,0,1,0,0,0, 32'h0, 32'h0000_2004, "R9");
        // R11: mode write, then mode write during entry is dropped
        step(0,0,0,0,0,0,1,1,0, 32'h0, 32'h0, "R11");
        // R7: break and interrupt together
        step(1,0,1,1,0,0,1,0,1, 32'h0000_4000, 32'h0, "R7");
        step(0,0,0,0,0,1,0,0,0, 32'h0, 32'h0000_4000, "R9");
        // R7: both break kinds together, one entry
        step(1,1,0,0,0,0,0,0,0, 32'h0000_4400, 32'h0, "R7");
        step(1,0,0,0,0,0,0,0,0, 32'h0000_4404, 32'h0, "R7");
        step(0,0,0,0,0,1,1,0,0, 32'h0, 32'h0000_4400, "R11");
        step(0,0,1,1,0,0,0,0,0, 32'h0, 32'h0, "R8");
        idle("R1");
        repeat (3) @(posedge clk);
        @(negedge clk);
        finish_run();
    end

endmodule